// File: doc/BRIEF.md
# Exception Cause Arbiter

This block sits beside the execute stage of a processor pipeline. Every cycle it looks at the qualified interrupt request and at the instruction currently executing. From these it decides whether an exception has to be raised and which of the seven possible causes is reported. The instruction side supplies decode flags for trap, break, illegal and multiply/divide instructions, the size and address of any data access, and the divide operands with their signedness. The block finds misaligned accesses and divide errors itself. It does not perform the access or compute the quotient.

Each cause that software can provoke can be removed at build time. A removed cause never raises an exception; the instruction then completes with an unspecified result. The multiply and divide units can also be declared absent. A multiply or divide then raises the unimplemented-instruction cause, so that software can emulate it. The result is a registered, one-cycle strobe with a 3-bit cause code. The pipeline uses it to redirect to the handler. The cycle after the strobe is a flush shadow, and nothing is raised in it.

Top module: `exc_cause_arb`

## Requirements
- R1: When several causes are active in the same cycle, the lowest code wins. The codes are: 0 interrupt, 1 trap, 2 illegal instruction, 3 unimplemented instruction, 4 break, 5 misaligned data address, 6 division error.
- R2: An interrupt request raises code 0 whether `ex_valid` is high or low. Every other cause is considered only when `ex_valid` is 1.
- R3: A word access (`mem_size` = 2'b10) with `mem_en` = 1 whose address bits [1:0] are not 00 raises code 5.
- R4: A halfword access (`mem_size` = 2'b01) with `mem_en` = 1 whose address bit 0 is 1 raises code 5.
- R5: These never raise code 5: a byte access (`mem_size` = 2'b00), the reserved size 2'b11, any access with `mem_en` = 0, and aligned word or halfword addresses.
- R6: A divide (`is_div` = 1) with a zero divisor raises code 6, whether the divide is signed or unsigned.
- R7: A signed divide of the most negative value (bit DATA_W-1 only set) by all ones raises code 6. The same operands with `div_signed` = 0 raise nothing, and so does a signed divide of any other dividend by all ones.
- R8: With the multiply unit absent (default), `is_mul` raises code 3. With the divide unit absent, `is_div` raises code 3 and division errors are not checked.
- R9: `exc_taken` rises in the cycle after the condition is presented and stays high for exactly one cycle. Conditions present while `exc_taken` is high are ignored. A condition that persists is reported again in the following cycle.
- R10: After reset, and in every cycle with no exception, `exc_taken` is 0 and `exc_cause` is 0.
- R11: A cause whose build-time enable is 0 (trap, illegal, unimplemented, break, misaligned, division error) never raises an exception. A lower-priority cause that is still enabled is reported in its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Qualified (already masked) interrupt request |
| ex_valid | input | 1 | An instruction is in the execute stage |
| is_trap | input | 1 | Decoded trap instruction |
| is_break | input | 1 | Decoded break instruction |
| is_illegal | input | 1 | Unknown instruction pattern |
| is_mul | input | 1 | Legal multiply instruction |
| is_div | input | 1 | Legal divide instruction |
| div_signed | input | 1 | Divide is signed |
| div_num | input | DATA_W | Dividend |
| div_den | input | DATA_W | Divisor |
| mem_en | input | 1 | Instruction is a load or store |
| mem_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| mem_addr | input | ADDR_W | Data access address |
| exc_taken | output | 1 | One-cycle exception strobe |
| exc_cause | output | 3 | Winning cause code, 0 when idle |

## Verification
Two kinds of overlap matter in this block. The first is a hardware interrupt arriving in the same cycle as an instruction that also carries software causes, such as a misaligned word store that also divides by zero. The bench presents such combinations in one cycle and checks that only the highest-ranked code comes out. It then removes the winner step by step and watches the next cause take its place. The second overlap is a persisting condition that lands in the flush-shadow cycle. The bench holds an interrupt high for three cycles and expects the strobe pattern high, low, high. A second instance, built with trap, misalignment and divide-error detection removed, is driven with the same stimulus. For it, the bench expects either silence or the next enabled cause.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int NUM_CAUSES = 7;
   localparam int CAUSE_W    = 3;

   // Codes double as priority: lower value wins.
   typedef enum logic [CAUSE_W-1:0] {
      C_IRQ      = 3'd0,
      C_TRAP     = 3'd1,
      C_ILLEGAL  = 3'd2,
      C_UNIMPL   = 3'd3,
      C_BREAK    = 3'd4,
      C_MISALIGN = 3'd5,
      C_DIVERR   = 3'd6
   } cause_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;

endpackage

// File: rtl/exc_sw_detect.sv
module exc_sw_detect import exc_pkg::*; #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter bit EN_MISALIGN = 1'b1,
   parameter bit EN_DIVERR   = 1'b1,
   parameter bit HAS_DIV     = 1'b1
) (
   input  logic              mem_en,
   input  logic [1:0]        mem_size,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic              is_div,
   input  logic              div_signed,
   input  logic [DATA_W-1:0] div_num,
   input  logic [DATA_W-1:0] div_den,
   output logic              misalign,
   output logic              div_err
);

   localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("exc_sw_detect: ADDR_W must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_data_w
      $error("exc_sw_detect: DATA_W must be at least 2");
   end

   // Marks every input as consumed whichever variant is built.
   logic unused_inputs;
   assign unused_inputs = ^{mem_en, mem_size, mem_addr, is_div, div_signed, div_num, div_den};

   if (EN_MISALIGN) begin : g_misalign
      acc_size_e sz;
      logic      bad_lo;
      assign sz = acc_size_e'(mem_size);
      always_comb begin
         unique case (sz)
            SZ_HALF: bad_lo = mem_addr[0];
            SZ_WORD: bad_lo = |mem_addr[1:0];
            default: bad_lo = 1'b0;
         endcase
      end
      assign misalign = mem_en & bad_lo;
   end else begin : g_no_misalign
      assign misalign = 1'b0;
   end

   if (EN_DIVERR && HAS_DIV) begin : g_diverr
      logic den_zero;
      logic ovf;
      assign den_zero = (div_den == '0);
      assign ovf      = div_signed & (div_num == MOST_NEG) & (div_den == '1);
      assign div_err  = is_div & (den_zero | ovf);
   end else begin : g_no_diverr
      assign div_err = 1'b0;
   end

   // R5: byte and reserved sizes never report misalignment
   always_comb begin
      if (mem_size == SZ_BYTE || mem_size == SZ_RSVD)
         p_byte_never_misaligned_r5: assert (misalign !== 1'b1);
   end

endmodule

// File: rtl/exc_prio_enc.sv
module exc_prio_enc #(
   parameter int N  = 7,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   if (N < 2) begin : g_bad_n
      $error("exc_prio_enc: N must be at least 2");
   end

   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   // R1: the chosen index is requested and nothing of lower index is
   always_comb begin
      if (any === 1'b1) begin
         p_winner_requested_r1: assert (req[idx]);
         p_no_lower_pending_r1: assert ((req & ((N'(1) << idx) - N'(1))) == '0);
      end
   end

endmodule

// File: rtl/exc_cause_arb.sv
module exc_cause_arb import exc_pkg::*; #(
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 32,
   parameter bit EN_TRAP      = 1'b1,
   parameter bit EN_ILLEGAL   = 1'b1,
   parameter bit EN_UNIMPL    = 1'b1,
   parameter bit EN_BREAK     = 1'b1,
   parameter bit EN_MISALIGN  = 1'b1,
   parameter bit EN_DIVERR    = 1'b1,
   parameter bit HAS_MUL_UNIT = 1'b0,
   parameter bit HAS_DIV_UNIT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               irq_req,
   input  logic               ex_valid,
   input  logic               is_trap,
   input  logic               is_break,
   input  logic               is_illegal,
   input  logic               is_mul,
   input  logic               is_div,
   input  logic               div_signed,
   input  logic [DATA_W-1:0]  div_num,
   input  logic [DATA_W-1:0]  div_den,
   input  logic               mem_en,
   input  logic [1:0]         mem_size,
   input  logic [ADDR_W-1:0]  mem_addr,
   output logic               exc_taken,
   output logic [CAUSE_W-1:0] exc_cause
);

   localparam int ENC_W = $clog2(NUM_CAUSES);
   localparam logic [NUM_CAUSES-1:0] CAUSE_KEEP =
      {EN_DIVERR, EN_MISALIGN, EN_BREAK, EN_UNIMPL, EN_ILLEGAL, EN_TRAP, 1'b1};

   if (ENC_W != CAUSE_W) begin : g_bad_cause_w
      $error("exc_cause_arb: cause width does not match cause count");
   end

   logic                  misalign;
   logic                  div_err;
   logic                  unimpl;
   logic [NUM_CAUSES-1:0] raw;
   logic [NUM_CAUSES-1:0] req;
   logic                  any;
   logic [CAUSE_W-1:0]    win;

   exc_sw_detect #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .EN_MISALIGN (EN_MISALIGN),
      .EN_DIVERR   (EN_DIVERR),
      .HAS_DIV     (HAS_DIV_UNIT)
   ) u_detect (
      .mem_en     (mem_en),
      .mem_size   (mem_size),
      .mem_addr   (mem_addr),
      .is_div     (is_div),
      .div_signed (div_signed),
      .div_num    (div_num),
      .div_den    (div_den),
      .misalign   (misalign),
      .div_err    (div_err)
   );

   assign unimpl = (is_mul & ~HAS_MUL_UNIT) | (is_div & ~HAS_DIV_UNIT);

   always_comb begin
      raw             = '0;
      raw[C_IRQ]      = irq_req;
      raw[C_TRAP]     = ex_valid & is_trap;
      raw[C_ILLEGAL]  = ex_valid & is_illegal;
      raw[C_UNIMPL]   = ex_valid & unimpl;
      raw[C_BREAK]    = ex_valid & is_break;
      raw[C_MISALIGN] = ex_valid & misalign;
      raw[C_DIVERR]   = ex_valid & div_err;
   end

   assign req = raw & CAUSE_KEEP;

   exc_prio_enc #(
      .N  (NUM_CAUSES),
      .IW (CAUSE_W)
   ) u_prio (
      .req (req),
      .any (any),
      .idx (win)
   );

   // One-cycle strobe; the cycle after it is a flush shadow.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exc_taken <= 1'b0;
         exc_cause <= '0;
      end else if (exc_taken) begin
         exc_taken <= 1'b0;
         exc_cause <= '0;
      end else begin
         exc_taken <= any;
         exc_cause <= any ? win : '0;
      end
   end

   p_pulse_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      exc_taken |=> !exc_taken);

   p_idle_cause_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_taken |-> exc_cause == '0);

   p_irq_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_taken && irq_req) |=> (exc_taken && exc_cause == C_IRQ));

   p_no_sw_without_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_taken && !irq_req && !ex_valid) |=> !exc_taken);

   p_trap_removed_r11: assert property (@(posedge clk) disable iff (!rst_n)
      exc_taken |-> (EN_TRAP || exc_cause != C_TRAP));

endmodule

// File: tb/exc_cause_arb_tb.sv
module exc_cause_arb_tb;

   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          irq_req, ex_valid, is_trap, is_break, is_illegal, is_mul, is_div, div_signed;
   logic [DW-1:0] div_num, div_den;
   logic          mem_en;
   logic [1:0]    mem_size;
   logic [AW-1:0] mem_addr;
   logic          exc_taken, min_taken;
   logic [2:0]    exc_cause, min_cause;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   exc_cause_arb #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ex_valid(ex_valid),
      .is_trap(is_trap), .is_break(is_break), .is_illegal(is_illegal),
      .is_mul(is_mul), .is_div(is_div), .div_signed(div_signed),
      .div_num(div_num), .div_den(div_den), .mem_en(mem_en),
      .mem_size(mem_size), .mem_addr(mem_addr),
      .exc_taken(exc_taken), .exc_cause(exc_cause));

   // Build with trap, misalignment and divide-error detection removed.
   exc_cause_arb #(.ADDR_W(AW), .DATA_W(DW), .EN_TRAP(1'b0),
                   .EN_MISALIGN(1'b0), .EN_DIVERR(1'b0)) u_dut_min (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ex_valid(ex_valid),
      .is_trap(is_trap), .is_break(is_break), .is_illegal(is_illegal),
      .is_mul(is_mul), .is_div(is_div), .div_signed(div_signed),
      .div_num(div_num), .div_den(div_den), .mem_en(mem_en),
      .mem_size(mem_size), .mem_addr(mem_addr),
      .exc_taken(min_taken), .exc_cause(min_cause));

   task automatic check(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      irq_req = 0; ex_valid = 0; is_trap = 0; is_break = 0; is_illegal = 0;
      is_mul = 0; is_div = 0; div_signed = 0; div_num = 1; div_den = 1;
      mem_en = 0; mem_size = 2'b00; mem_addr = '0;
   endtask

   // Inputs already set; result visible one negedge later, then a shadow cycle.
   task automatic step(string tag, int et, int ec, int mt, int mc);
      @(negedge clk);
      check({tag, " taken"}, exc_taken, et);
      check({tag, " cause"}, exc_cause, ec);
      check({tag, " min taken"}, min_taken, mt);
      check({tag, " min cause"}, min_cause, mc);
      idle_inputs();
      @(negedge clk);
   endtask

   task automatic t_reset();
      idle_inputs();
      rst_n = 0;
      irq_req = 1;
      repeat (3) @(negedge clk);
      check("R10 reset taken", exc_taken, 0);
      check("R10 reset cause", exc_cause, 0);
      idle_inputs();
      rst_n = 1;
      repeat (2) @(negedge clk);
      check("R10 idle taken", exc_taken, 0);
      check("R10 idle cause", exc_cause, 0);
   endtask

   task automatic t_single_causes();
      irq_req = 1;                           step("R1 irq", 1, 0, 1, 0);
      ex_valid = 1; is_trap = 1;             step("R1 trap", 1, 1, 0, 0);
      ex_valid = 1; is_illegal = 1;          step("R1 illegal", 1, 2, 1, 2);
      ex_valid = 1; is_mul = 1;              step("R8 mul unimpl", 1, 3, 1, 3);
      ex_valid = 1; is_break = 1;            step("R1 break", 1, 4, 1, 4);
   endtask

   task automatic t_misalign();
      ex_valid = 1; mem_en = 1; mem_size = 2'b10; mem_addr = 32'h1002; step("R3 word+2", 1, 5, 0, 0);
      ex_valid = 1; mem_en = 1; mem_size = 2'b10; mem_addr = 32'h1001; step("R3 word+1", 1, 5, 0, 0);
      ex_valid = 1; mem_en = 1; mem_size = 2'b10; mem_addr = 32'h1004; step("R5 word aligned", 0, 0, 0, 0);
      ex_valid = 1; mem_en = 1; mem_size = 2'b01; mem_addr = 32'h2003; step("R4 half odd", 1, 5, 0, 0);
      ex_valid = 1; mem_en = 1; mem_size = 2'b01; mem_addr = 32'h2002; step("R5 half even", 0, 0, 0, 0);
      ex_valid = 1; mem_en = 1; mem_size = 2'b00; mem_addr = 32'h3003; step("R5 byte odd", 0, 0, 0, 0);
      ex_valid = 1; mem_en = 1; mem_size = 2'b11; mem_addr = 32'h3003; step("R5 reserved size", 0, 0, 0, 0);
      ex_valid = 1; mem_en = 0; mem_size = 2'b10; mem_addr = 32'h3003; step("R5 no access", 0, 0, 0, 0);
   endtask

   task automatic t_divide();
      ex_valid = 1; is_div = 1; div_signed = 0; div_num = 32'd9; div_den = 0;
      step("R6 unsigned zero", 1, 6, 0, 0);
      ex_valid = 1; is_div = 1; div_signed = 1; div_num = 32'd9; div_den = 0;
      step("R6 signed zero", 1, 6, 0, 0);
      ex_valid = 1; is_div = 1; div_signed = 1; div_num = 32'h8000_0000; div_den = 32'hFFFF_FFFF;
      step("R7 signed overflow", 1, 6, 0, 0);
      ex_valid = 1; is_div = 1; div_signed = 0; div_num = 32'h8000_0000; div_den = 32'hFFFF_FFFF;
      step("R7 unsigned same operands", 0, 0, 0, 0);
      ex_valid = 1; is_div = 1; div_signed = 1; div_num = 32'd7; div_den = 32'hFFFF_FFFF;
      step("R7 signed other dividend", 0, 0, 0, 0);
      ex_valid = 1; is_div = 0; div_signed = 1; div_num = 32'd7; div_den = 0;
      step("R6 not a divide", 0, 0, 0, 0);
   endtask

   task automatic t_priority();
      irq_req = 1; ex_valid = 1; is_trap = 1; is_illegal = 1; is_mul = 1; is_break = 1;
      mem_en = 1; mem_size = 2'b10; mem_addr = 32'h2; is_div = 1; div_den = 0;
      step("R1 all active", 1, 0, 1, 0);
      ex_valid = 1; is_trap = 1; is_illegal = 1; is_break = 1;
      mem_en = 1; mem_size = 2'b10; mem_addr = 32'h2; is_div = 1; div_den = 0;
      step("R1 trap over rest", 1, 1, 1, 2);
      ex_valid = 1; is_illegal = 1; mem_en = 1; mem_size = 2'b01; mem_addr = 32'h1;
      is_div = 1; div_den = 0;
      step("R1 illegal over data", 1, 2, 1, 2);
      ex_valid = 1; is_break = 1; mem_en = 1; mem_size = 2'b10; mem_addr = 32'h3;
      step("R1 break over misalign", 1, 4, 1, 4);
      ex_valid = 1; mem_en = 1; mem_size = 2'b10; mem_addr = 32'h3; is_div = 1; div_den = 0;
      step("R1 misalign over diverr", 1, 5, 0, 0);
      ex_valid = 1; is_trap = 1; is_break = 1;
      step("R11 trap removed falls to break", 1, 1, 1, 4);
   endtask

   task automatic t_valid_gate();
      ex_valid = 0; is_trap = 1; is_illegal = 1; mem_en = 1; mem_size = 2'b10; mem_addr = 32'h1;
      step("R2 no valid sw", 0, 0, 0, 0);
      ex_valid = 0; irq_req = 1;
      step("R2 irq without valid", 1, 0, 1, 0);
   endtask

   task automatic t_shadow();
      irq_req = 1;
      @(negedge clk);
      check("R9 first pulse", exc_taken, 1);
      @(negedge clk);
      check("R9 shadow low", exc_taken, 0);
      check("R9 shadow cause", exc_cause, 0);
      @(negedge clk);
      check("R9 repeat pulse", exc_taken, 1);
      idle_inputs();
      @(negedge clk);
      check("R9 end low", exc_taken, 0);
      @(negedge clk);
      check("R9 stays low", exc_taken, 0);
   endtask

   initial begin
      t_reset();
      t_single_causes();
      t_misalign();
      t_divide();
      t_priority();
      t_valid_gate();
      t_shadow();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule